// File: doc/BRIEF.md
# Peripheral Interrupt Router

The router sits between off-core peripherals and the two interrupt inputs of a CPU core. It takes a set of peripheral request lines and a smaller set of virtual lines that software raises by writing a register. Every line is conditioned on its own before it reaches the core. Peripheral lines pass through a two-flop synchronizer. They are then detected as a level or as an edge, with a per-line polarity. Each line carries an enable and a blocking flag, and a one-bit destination that picks which of the two CPU outputs it drives.

Edge events and virtual raises set a per-line pending latch. Level lines are forwarded for as long as the input holds its active value. A line set up as blocking is removed from its output once it has been delivered. It stays off until the core sends an end-of-interrupt response that names the line by index. That response also clears the line's pending latch.

Configuration uses a flat 32-bit register bus. A write takes effect on the next clock edge. A read returns its data one cycle after the read strobe.

Top module: `periphIrqRouter`

## Requirements
- R1: After reset both CPU outputs are low and every configuration bit reads back as 0.
- R2: A peripheral line with sensitivity 0 is a level line. With polarity 1 it is active while its input is high, and with polarity 0 it is active while its input is low. An enabled, unblocked level line drives its CPU output 3 cycles after the input change, and the output follows the input back down with the same latency.
- R3: A peripheral line with sensitivity 1 is an edge line. Polarity 1 selects the rising edge and polarity 0 selects the falling edge. The qualifying edge sets a pending latch that is visible on the output 4 cycles after the input change. The latch holds through later input changes of either direction until an end-of-interrupt response clears it.
- R4: A destination bit of 0 routes the line to cpuIrq[0], and a destination bit of 1 routes it to cpuIrq[1]. Each output is the OR of its own lines, so both outputs can be high at once.
- R5: A line whose enable bit is 0 never drives an output. An edge or a virtual raise that arrives while the line is disabled is dropped and does not fire when the line is later enabled.
- R6: A line with its blocking bit set is delivered for one cycle and then held off. It stays off until an end-of-interrupt response for that line, and edges arriving while it is held off are dropped. A level line still active at that response is delivered again one cycle later.
- R7: An end-of-interrupt response (eoiValid with eoiLine) clears the pending latch and the blocked state of the indexed line. The output falls one cycle after the response is taken. An index at or above the line count has no effect.
- R8: Virtual lines occupy indexes 64 to 79. Writing a 1 to bit j of the raise register in bank b sets the pending latch of line 32*b+j. Virtual lines store no polarity or sensitivity, and those bits read back 0.
- R9: The register address is kind*4 + bank. Bank b holds lines 32*b to 32*b+31 at bit positions 0 to 31. The kinds are 0 polarity, 1 sensitivity, 2 blocking, 3 enable, 4 destination and 5 raise. Read data appears one cycle after regRdEn and holds otherwise. The raise kind, any unused kind, bank 3 and bits beyond line 79 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periphIrq | input | 64 | Peripheral request lines, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 5 | Register word address: kind in bits 4:2, bank in bits 1:0 |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid one cycle after regRdEn |
| eoiValid | input | 1 | End-of-interrupt response strobe from the core |
| eoiLine | input | 7 | Line index carried by the end-of-interrupt response |
| cpuIrq | output | 2 | Active-high level requests to the core's two interrupt inputs |

## Verification
The bench targets the cases where one flag interacts with another.

- Edge latching: an edge line must stay asserted after its input returns. A design that forwarded the raw edge would drop the request after one cycle.
- Blocking: a blocking level line must go quiet after one cycle and come back only after its end-of-interrupt response. A design that ignored the flag would hold the output high, and one that never cleared it would lose the second delivery.
- Enable gating: edges and virtual raises that arrive while a line is disabled must be dropped. A design that latched them would fire as soon as the line was enabled.
- Register map: out-of-range response indexes, out-of-range banks and the polarity bits of virtual lines must all stay inert. A decoder that aliased these would corrupt the real lines' state.

// File: rtl/routerPkg.sv
`timescale 1ns/1ps
package routerPkg;
  localparam int REG_W     = 32;
  localparam int KIND_W    = 3;
  localparam int NUM_KINDS = 6;
  localparam int MAX_BANK_W = 4;
  localparam int NUM_OUTS  = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_POL   = 3'd0,
    KIND_SENS  = 3'd1,
    KIND_BLK   = 3'd2,
    KIND_EN    = 3'd3,
    KIND_DST   = 3'd4,
    KIND_RAISE = 3'd5
  } regKind_t;

  // Strobes from the bus decoder to the datapath
  typedef struct packed {
    logic [NUM_KINDS-1:0]  wrKind;  // one-hot write strobe per register kind
    logic                  rdReq;
    logic [MAX_BANK_W-1:0] bank;
    regKind_t              kind;
    logic [REG_W-1:0]      wrData;
  } ctrlStrobes_t;
endpackage

// File: rtl/routerLine.sv
`timescale 1ns/1ps
module routerLine #(
  parameter bit IS_VIRTUAL = 1'b0
)(
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic polBit,
  input  logic sensBit,
  input  logic enBit,
  input  logic blkBit,
  input  logic raiseHit,
  input  logic eoiHit,
  output logic fwd
);
  logic syncA, syncB, prevB;
  logic pending, blocked;
  logic levelActive, edgeSeen, trigger, request;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  always_comb begin
    levelActive = (syncB == polBit);
    edgeSeen    = polBit ? (syncB & ~prevB) : (~syncB & prevB);
    trigger     = IS_VIRTUAL ? raiseHit : (sensBit & edgeSeen);
    request     = (IS_VIRTUAL || sensBit) ? pending : levelActive;
    fwd         = request & enBit & ~blocked;
  end

  // A new event wins over a response arriving in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      blocked <= 1'b0;
    end else begin
      if (trigger && enBit && !blocked) pending <= 1'b1;
      else if (eoiHit)                  pending <= 1'b0;
      if (fwd && blkBit)                blocked <= 1'b1;
      else if (eoiHit)                  blocked <= 1'b0;
    end
  end
endmodule

// File: rtl/routerCtrl.sv
`timescale 1ns/1ps
module routerCtrl import routerPkg::*; #(
  parameter int NUM_LINES = 80,
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 2,
  parameter int LINE_W    = 7
)(
  input  logic                     regWrEn,
  input  logic                     regRdEn,
  input  logic [KIND_W+BANK_W-1:0] regAddr,
  input  logic [REG_W-1:0]         regWrData,
  input  logic                     eoiValid,
  input  logic [LINE_W-1:0]        eoiLine,
  output ctrlStrobes_t             strobes,
  output logic [NUM_LINES-1:0]     eoiHit
);
  logic [KIND_W-1:0] kindField;
  logic [BANK_W-1:0] bankField;
  logic              bankOk;

  always_comb begin
    kindField      = regAddr[KIND_W+BANK_W-1:BANK_W];
    bankField      = regAddr[BANK_W-1:0];
    bankOk         = (32'(bankField) < NUM_BANKS);
    strobes        = '0;
    strobes.bank   = MAX_BANK_W'(bankField);
    strobes.kind   = regKind_t'(kindField);
    strobes.wrData = regWrData;
    strobes.rdReq  = regRdEn;
    for (int k = 0; k < NUM_KINDS; k++)
      strobes.wrKind[k] = regWrEn && bankOk && (32'(kindField) == k);
  end

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++)
      eoiHit[i] = eoiValid && (32'(eoiLine) == i);
  end
endmodule

// File: rtl/routerDatapath.sv
`timescale 1ns/1ps
module routerDatapath import routerPkg::*; #(
  parameter int NUM_PERIPH = 64,
  parameter int NUM_VIRT   = 16
)(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_PERIPH-1:0]          periphIrq,
  input  ctrlStrobes_t                   strobes,
  input  logic [NUM_PERIPH+NUM_VIRT-1:0] eoiHit,
  output logic [REG_W-1:0]               regRdData,
  output logic [NUM_OUTS-1:0]            cpuIrq
);
  localparam int NUM_LINES = NUM_PERIPH + NUM_VIRT;

  logic [NUM_LINES-1:0] polReg, sensReg, blkReg, enReg, dstReg;
  logic [NUM_LINES-1:0] rawAll, raiseHit, fwdVec, srcVec, bankSel;
  logic [REG_W-1:0]     rdWord;
  logic [NUM_OUTS-1:0]  irqNext;

  assign rawAll = {{NUM_VIRT{1'b0}}, periphIrq};

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++)
      bankSel[i] = (32'(strobes.bank) == i / REG_W);
  end

  // Configuration banks; polarity and sensitivity exist only for peripheral lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polReg  <= '0;
      sensReg <= '0;
      blkReg  <= '0;
      enReg   <= '0;
      dstReg  <= '0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (bankSel[i]) begin
          if (strobes.wrKind[int'(KIND_POL)] && i < NUM_PERIPH)
            polReg[i] <= strobes.wrData[i % REG_W];
          if (strobes.wrKind[int'(KIND_SENS)] && i < NUM_PERIPH)
            sensReg[i] <= strobes.wrData[i % REG_W];
          if (strobes.wrKind[int'(KIND_BLK)])
            blkReg[i] <= strobes.wrData[i % REG_W];
          if (strobes.wrKind[int'(KIND_EN)])
            enReg[i] <= strobes.wrData[i % REG_W];
          if (strobes.wrKind[int'(KIND_DST)])
            dstReg[i] <= strobes.wrData[i % REG_W];
        end
      end
    end
  end

  always_comb begin
    raiseHit = '0;
    for (int i = NUM_PERIPH; i < NUM_LINES; i++)
      raiseHit[i] = strobes.wrKind[int'(KIND_RAISE)] && bankSel[i] && strobes.wrData[i % REG_W];
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    routerLine #(.IS_VIRTUAL(g >= NUM_PERIPH)) uLine (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (rawAll[g]),
      .polBit   (polReg[g]),
      .sensBit  (sensReg[g]),
      .enBit    (enReg[g]),
      .blkBit   (blkReg[g]),
      .raiseHit (raiseHit[g]),
      .eoiHit   (eoiHit[g]),
      .fwd      (fwdVec[g])
    );
  end

  for (genvar o = 0; o < NUM_OUTS; o++) begin : gOut
    if (o == 0) begin : gLow
      assign irqNext[o] = |(fwdVec & ~dstReg);
    end else begin : gHigh
      assign irqNext[o] = |(fwdVec & dstReg);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuIrq <= '0;
    else       cpuIrq <= irqNext;
  end

  always_comb begin
    case (strobes.kind)
      KIND_POL:  srcVec = polReg;
      KIND_SENS: srcVec = sensReg;
      KIND_BLK:  srcVec = blkReg;
      KIND_EN:   srcVec = enReg;
      KIND_DST:  srcVec = dstReg;
      default:   srcVec = '0;
    endcase
    rdWord = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (bankSel[i]) rdWord[i % REG_W] = srcVec[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              regRdData <= '0;
    else if (strobes.rdReq) regRdData <= rdWord;
  end
endmodule

// File: rtl/periphIrqRouter.sv
`timescale 1ns/1ps
module periphIrqRouter import routerPkg::*; #(
  parameter int NUM_PERIPH = 64,
  parameter int NUM_VIRT   = 16,
  localparam int NUM_LINES = NUM_PERIPH + NUM_VIRT,
  localparam int NUM_BANKS = (NUM_LINES + REG_W - 1) / REG_W,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int ADDR_W    = KIND_W + BANK_W
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PERIPH-1:0] periphIrq,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [REG_W-1:0]      regWrData,
  output logic [REG_W-1:0]      regRdData,
  input  logic                  eoiValid,
  input  logic [LINE_W-1:0]     eoiLine,
  output logic [NUM_OUTS-1:0]   cpuIrq
);
  ctrlStrobes_t         strobes;
  logic [NUM_LINES-1:0] eoiHit;

  routerCtrl #(
    .NUM_LINES (NUM_LINES),
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .LINE_W    (LINE_W)
  ) uCtrl (
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .eoiValid  (eoiValid),
    .eoiLine   (eoiLine),
    .strobes   (strobes),
    .eoiHit    (eoiHit)
  );

  routerDatapath #(
    .NUM_PERIPH (NUM_PERIPH),
    .NUM_VIRT   (NUM_VIRT)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .periphIrq (periphIrq),
    .strobes   (strobes),
    .eoiHit    (eoiHit),
    .regRdData (regRdData),
    .cpuIrq    (cpuIrq)
  );
endmodule

// File: rtl/routerChecker.sv
`timescale 1ns/1ps
module routerChecker #(
  parameter int NUM_LINES = 80,
  parameter int LINE_W    = 7,
  parameter int NUM_KINDS = 6
)(
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic                 regRdEn,
  input logic [31:0]          regRdData,
  input logic                 eoiValid,
  input logic [LINE_W-1:0]    eoiLine,
  input logic [NUM_KINDS-1:0] wrKind,
  input logic [NUM_LINES-1:0] eoiHit
);
  a_r7_eoi_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(eoiHit));

  a_r7_eoi_out_of_range: assert property (@(posedge clk) disable iff (!rstN)
    (eoiValid && 32'(eoiLine) >= NUM_LINES) |-> (eoiHit == '0));

  a_r7_eoi_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (eoiValid && 32'(eoiLine) < NUM_LINES) |-> ($countones(eoiHit) == 1));

  a_r7_eoi_idle: assert property (@(posedge clk) disable iff (!rstN)
    !eoiValid |-> (eoiHit == '0));

  a_r9_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrKind));

  a_r9_write_gated: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> (wrKind == '0));

  a_r9_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> $stable(regRdData));
endmodule

bind periphIrqRouter routerChecker #(
  .NUM_LINES (NUM_LINES),
  .LINE_W    (LINE_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regRdData (regRdData),
  .eoiValid  (eoiValid),
  .eoiLine   (eoiLine),
  .wrKind    (strobes.wrKind),
  .eoiHit    (eoiHit)
);

// File: tb/periphIrqRouter_test.sv
`timescale 1ns/1ps
module periphIrqRouter_test;
  localparam int KPOL = 0, KSENS = 1, KBLK = 2, KEN = 3, KDST = 4, KRAISE = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] periphIrq = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        eoiValid = 1'b0;
  logic [6:0]  eoiLine = '0;
  logic [1:0]  cpuIrq;

  int  cycleCnt = 0;
  int  testsRun = 0;
  int  testsFailed = 0;
  bit  done = 1'b0;

  typedef struct {
    int          cyc;
    bit          isRd;
    logic [31:0] val;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  periphIrqRouter uut (
    .clk(clk), .rstN(rstN), .periphIrq(periphIrq),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .eoiValid(eoiValid), .eoiLine(eoiLine), .cpuIrq(cpuIrq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // Monitor: compares queued expectations at their due cycle
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].cyc <= cycleCnt) begin
      logic [31:0] act;
      act = expQ[0].isRd ? regRdData : {30'b0, cpuIrq};
      testsRun++;
      if (act !== expQ[0].val) begin
        testsFailed++;
        $display("FAIL %s: actual=%h expected=%h (cycle %0d)", expQ[0].tag, act, expQ[0].val, cycleCnt);
      end
      void'(expQ.pop_front());
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (expQ.size() > 0) tick(1);
    tick(1);
  endtask

  task automatic expIrq(int off, logic [1:0] v, string tag);
    expItem_t it;
    it.cyc = cycleCnt + off; it.isRd = 1'b0; it.val = {30'b0, v}; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic wrReg(int kind, int bank, logic [31:0] d);
    regWrEn = 1'b1; regAddr = 5'(kind * 4 + bank); regWrData = d;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(int kind, int bank, logic [31:0] ev, string tag);
    expItem_t it;
    regRdEn = 1'b1; regAddr = 5'(kind * 4 + bank);
    it.cyc = cycleCnt + 1; it.isRd = 1'b1; it.val = ev; it.tag = tag;
    expQ.push_back(it);
    tick(1);
    regRdEn = 1'b0;
    drain();
  endtask

  task automatic sendEoi(int line);
    eoiValid = 1'b1; eoiLine = 7'(line);
    tick(1);
    eoiValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual=hung expected=complete");
      finishRun();
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);

    // R1: reset state
    expIrq(0, 2'b00, "R1 outputs low after reset");
    drain();
    rdReg(KEN, 0, 32'h0, "R1 enable bank0 cleared");
    rdReg(KPOL, 1, 32'h0, "R1 polarity bank1 cleared");

    // R2: active-high level, line 3 to output 0
    wrReg(KPOL, 0, 32'h8);
    wrReg(KEN, 0, 32'h8);
    expIrq(1, 2'b00, "R5 disabled active-low lines stay silent");
    drain();
    periphIrq[3] = 1'b1;
    expIrq(2, 2'b00, "R2 level not yet through synchronizer");
    expIrq(3, 2'b01, "R2 active-high level forwarded");
    drain();
    periphIrq[3] = 1'b0;
    expIrq(2, 2'b01, "R2 level still held");
    expIrq(3, 2'b00, "R2 level released");
    drain();

    // R2/R4: active-low level, line 40 to output 1
    wrReg(KDST, 1, 32'h100);
    wrReg(KEN, 1, 32'h100);
    expIrq(0, 2'b00, "R2 before enable reaches output");
    expIrq(1, 2'b10, "R4 active-low line on output 1");
    drain();
    periphIrq[40] = 1'b1;
    expIrq(2, 2'b10, "R2 active-low still active");
    expIrq(3, 2'b00, "R2 active-low released by high input");
    drain();
    wrReg(KEN, 1, 32'h0);
    periphIrq[40] = 1'b0;
    tick(4);

    // R3: rising edge on line 5
    wrReg(KPOL, 0, 32'h28);
    wrReg(KSENS, 0, 32'h20);
    wrReg(KEN, 0, 32'h28);
    periphIrq[5] = 1'b1;
    expIrq(3, 2'b00, "R3 edge not yet latched");
    expIrq(4, 2'b01, "R3 rising edge latched");
    expIrq(8, 2'b01, "R3 latch holds");
    drain();
    periphIrq[5] = 1'b0;
    expIrq(5, 2'b01, "R3 opposite edge leaves latch set");
    drain();
    sendEoi(5);
    expIrq(0, 2'b01, "R7 output before clear propagates");
    expIrq(1, 2'b00, "R7 response clears edge latch");
    drain();

    // R3: falling edge on line 6
    wrReg(KSENS, 0, 32'h60);
    periphIrq[6] = 1'b1;
    tick(4);
    wrReg(KEN, 0, 32'h68);
    expIrq(1, 2'b00, "R3 rising edge ignored for falling-edge line");
    drain();
    periphIrq[6] = 1'b0;
    expIrq(3, 2'b00, "R3 falling edge in flight");
    expIrq(4, 2'b01, "R3 falling edge latched");
    drain();
    sendEoi(6);
    expIrq(1, 2'b00, "R7 falling-edge latch cleared");
    drain();

    // R5: edge while disabled is dropped
    wrReg(KEN, 0, 32'h28);
    periphIrq[6] = 1'b1;
    tick(4);
    periphIrq[6] = 1'b0;
    tick(5);
    wrReg(KEN, 0, 32'h68);
    expIrq(1, 2'b00, "R5 edge while disabled dropped");
    expIrq(3, 2'b00, "R5 edge while disabled still dropped");
    drain();

    // R6: blocking level line 7
    wrReg(KPOL, 0, 32'hA8);
    wrReg(KBLK, 0, 32'h80);
    wrReg(KEN, 0, 32'hE8);
    periphIrq[7] = 1'b1;
    expIrq(2, 2'b00, "R6 before delivery");
    expIrq(3, 2'b01, "R6 delivered");
    expIrq(4, 2'b00, "R6 held off after delivery");
    expIrq(7, 2'b00, "R6 still held off");
    drain();
    sendEoi(7);
    expIrq(0, 2'b00, "R6 response not yet effective");
    expIrq(1, 2'b01, "R6 redelivered after response");
    expIrq(2, 2'b00, "R6 held off again");
    drain();
    periphIrq[7] = 1'b0;
    tick(4);
    sendEoi(7);
    expIrq(1, 2'b00, "R6 idle after release");
    drain();

    // R8: virtual line 66 to output 1
    wrReg(KDST, 2, 32'h4);
    wrReg(KEN, 2, 32'h5);
    wrReg(KRAISE, 2, 32'h4);
    expIrq(0, 2'b00, "R8 raise in flight");
    expIrq(1, 2'b10, "R8 virtual raise forwarded");
    expIrq(4, 2'b10, "R8 virtual raise held");
    drain();
    periphIrq[3] = 1'b1;
    expIrq(3, 2'b11, "R4 both outputs active");
    drain();
    periphIrq[3] = 1'b0;
    expIrq(3, 2'b10, "R4 output 0 drops independently");
    drain();
    sendEoi(100);
    expIrq(1, 2'b10, "R7 out-of-range index ignored");
    expIrq(3, 2'b10, "R7 out-of-range index still ignored");
    drain();
    sendEoi(66);
    expIrq(1, 2'b00, "R7 virtual latch cleared");
    drain();

    // R5: raise on a disabled virtual line
    wrReg(KRAISE, 2, 32'h8);
    expIrq(1, 2'b00, "R5 raise on disabled line");
    expIrq(3, 2'b00, "R5 raise on disabled line stays off");
    drain();
    wrReg(KEN, 2, 32'hD);
    expIrq(1, 2'b00, "R5 dropped raise does not fire on enable");
    drain();

    // R8/R9: register map
    rdReg(KEN, 0, 32'hE8, "R9 enable bank0 readback");
    rdReg(KDST, 1, 32'h100, "R9 destination bank1 readback");
    wrReg(KPOL, 2, 32'hFFFF_FFFF);
    rdReg(KPOL, 2, 32'h0, "R8 virtual polarity not stored");
    wrReg(KBLK, 2, 32'hFFFF_FFFF);
    rdReg(KBLK, 2, 32'h0000_FFFF, "R9 bits beyond last line read 0");
    wrReg(KEN, 3, 32'hFFFF_FFFF);
    rdReg(KEN, 3, 32'h0, "R9 out-of-range bank reads 0");
    rdReg(KEN, 0, 32'hE8, "R9 out-of-range bank write ignored");
    rdReg(KRAISE, 2, 32'h0, "R9 raise kind reads 0");
    rdReg(6, 0, 32'h0, "R9 unused kind reads 0");

    done = 1'b1;
    finishRun();
  end
endmodule